// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Master

This block is a small bus-master sequencer that sits above a byte-level two-wire bus engine. It answers one question: has a serial memory finished its internal nonvolatile write? The host starts it once its own write transfer has been closed with a STOP. The sequencer then sends a START followed by the device's address byte, over and over, until the device acknowledges that byte. While the internal write is still running, the device refuses its address.

Each attempt that is not acknowledged is closed with a STOP before the next attempt begins. When an attempt is acknowledged, there are two outcomes. If the host has another read or write queued, the sequencer leaves the bus open so that command can go on at once without a fresh START. If nothing is queued, it closes the bus with a STOP. A programmable attempt limit ensures that a device which never answers ends in a timeout and not in an endless loop.

The sequencer talks to the bus engine one command at a time: START, send a byte and return its acknowledge, or STOP. Bit-level timing of the clock and data lines belongs to the engine. Each accepted request ends with a single-cycle done pulse, which comes with the outcome flags and the number of attempts used.

Top module: `ackpoll_master`

## Requirements
- R1: After a synchronous active-low reset, `done`, `timed_out`, `bus_held`, `eng_cmd_valid` and `attempts_used` are all zero, and no engine command is issued until a request arrives.
- R2: A `req` pulse is accepted only while the sequencer is idle. A `req`, or a change of `dev_addr`, `rw_bit` or `has_next` while an operation runs, has no effect on the bytes sent or on the outcome.
- R3: Every attempt is an engine START followed by one byte send. The byte is `dev_addr` in bits 7:1 and `rw_bit` in bit 0. Engine command codes are 0 = START, 1 = send byte, 2 = STOP.
- R4: At most one engine command is outstanding. A new `eng_cmd_valid` pulse is never issued before `eng_done` has answered the previous one.
- R5: When the address byte returns `eng_ack` = 0 and the limit has not been reached, the sequencer issues a STOP and then starts a new attempt.
- R6: When the address byte returns `eng_ack` = 1 and `has_next` was 1 at request time, no STOP follows. `done` comes with `bus_held` = 1 and `timed_out` = 0.
- R7: When the address byte returns `eng_ack` = 1 and `has_next` was 0, a STOP is issued and completed before `done`. `bus_held` = 0 and `timed_out` = 0.
- R8: When the attempt numbered `max_attempts` is refused, the sequencer issues a STOP and reports `done` with `timed_out` = 1 and `bus_held` = 0. A `max_attempts` of 0 behaves as 1. An acknowledge on the last permitted attempt counts as success.
- R9: `done` is high for exactly one clock per accepted request. Alongside it, `attempts_used` gives the number of address bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start polling (single-cycle pulse) |
| dev_addr | input | ADDR_W (7) | Device address placed in the upper bits of the polled byte |
| rw_bit | input | 1 | Direction bit placed in bit 0 of the polled byte |
| has_next | input | 1 | A further command follows, so leave the bus open on success |
| max_attempts | input | CNT_W (8) | Attempt limit (0 is taken as 1) |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last run ended without an acknowledge |
| bus_held | output | 1 | Last run ended with the bus left open for the next command |
| attempts_used | output | CNT_W (8) | Address bytes sent in the last run |
| eng_cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| eng_cmd | output | 2 | Engine command code |
| eng_wdata | output | ADDR_W+1 (8) | Byte to send with a byte command |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_ack | input | 1 | Acknowledge seen on the sent byte (valid with `eng_done`) |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Acknowledge on the very last permitted attempt.** An off-by-one limit compare would report a timeout here.
- **A limit of zero.** A wrong design would either never send a byte or loop without end.
- **Success with `has_next` set after several refusals.** A design that closes the bus anyway shows one STOP more than the retries need.
- **A `req` with altered inputs injected mid-run.** A design that re-samples its inputs would send a foreign address or end the run twice.
- **Command ordering and overlap.** The engine model tracks these on every command, so a sequencer that skips the wait on `eng_done`, or sends a STOP without a preceding byte, is caught.
- **Reset in the middle of a polling loop.** This must leave the bus engine untouched.

// File: rtl/ackpoll_pkg.sv
// Package: shared encodings of the acknowledge polling master.
// Assumes the byte engine decodes the two-bit command code given here.
package ackpoll_pkg;

    // Engine command codes; the engine decodes these values.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } bus_op_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WSTART,
        ST_ADDR,
        ST_WADDR,
        ST_STOP,
        ST_WSTOP,
        ST_FIN
    } seq_state_t;

    // Why the current STOP is being sent.
    typedef enum logic [1:0] {
        END_RETRY,
        END_OK,
        END_TIMEOUT
    } stop_why_t;

endpackage

// File: rtl/ackpoll_attempt_ctr.sv
// Module: counts polling attempts against a limit.
// Assumes the limit input is held steady for the whole run and that a
// limit of zero means one attempt.
module ackpoll_attempt_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             exhausted
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] limit_eff;

    // Map a zero limit to a single attempt.
    always_comb limit_eff = (limit == '0) ? ONE : limit;

    // Flag that no further attempt is allowed.
    always_comb exhausted = (count >= limit_eff);

    // Attempt counter: cleared per request, bumped per address byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (bump)   count <= count + ONE;
    end

    // The sequencer must never start an attempt beyond the limit.
    assert_no_bump_past_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> !exhausted);

    // The counter never exceeds the effective limit.
    assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> count <= limit_eff);

endmodule

// File: rtl/ackpoll_cmd_port.sv
// Module: single-outstanding command port toward the byte engine.
// Registers each issued command into a one-cycle strobe and keeps a
// pending flag until the engine answers. Assumes the engine gives exactly
// one done pulse per command.
module ackpoll_cmd_port
    import ackpoll_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  bus_op_t           op,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              eng_done,
    input  logic              eng_ack,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [BYTE_W-1:0] eng_wdata,
    output logic              cmd_done,
    output logic              cmd_ack
);
    bus_op_t           op_q;
    bus_op_t           last_op;
    logic              pending;
    logic [BYTE_W-1:0] byte_q;

    // Command strobe and the registered command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_cmd_valid <= 1'b0;
            op_q          <= OP_STOP;
            byte_q        <= '0;
        end else begin
            eng_cmd_valid <= issue;
            if (issue) begin
                op_q   <= op;
                byte_q <= wbyte;
            end
        end
    end

    // Outstanding flag: set on issue, cleared by the engine's done.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (issue)      pending <= 1'b1;
        else if (eng_done)   pending <= 1'b0;
    end

    // Previous command kind, kept for ordering checks.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_op <= OP_STOP;
        else if (issue) last_op <= op;
    end

    // Outputs toward the engine and back to the sequencer.
    always_comb begin
        eng_cmd   = op_q;
        eng_wdata = byte_q;
        cmd_done  = pending && eng_done;
        cmd_ack   = eng_ack;
    end

    // Only one engine command in flight.
    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !pending);

    // An address byte always follows a START.
    assert_byte_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_BYTE) |-> last_op == OP_START);

    // A STOP always follows an address byte.
    assert_stop_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_STOP) |-> last_op == OP_BYTE);

endmodule

// File: rtl/ackpoll_seq.sv
// Module: polling sequencer. It captures a request, walks
// START / address byte / STOP attempts and decides success, retry or
// timeout. Assumes the host raises req only after its write has been
// closed with STOP.
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              rw_bit,
    input  logic              has_next,
    input  logic [CNT_W-1:0]  max_attempts,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    input  logic              exhausted,
    output logic              issue,
    output bus_op_t           op,
    output logic [ADDR_W:0]   wbyte,
    output logic              ctr_clear,
    output logic              ctr_bump,
    output logic [CNT_W-1:0]  limit_q,
    output logic              done,
    output logic              timed_out,
    output logic              bus_held
);
    seq_state_t        state;
    stop_why_t         why;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              next_q;

    // Main state machine with request capture and outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            why       <= END_RETRY;
            addr_q    <= '0;
            rw_q      <= 1'b0;
            next_q    <= 1'b0;
            limit_q   <= '0;
            timed_out <= 1'b0;
            bus_held  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    addr_q    <= dev_addr;
                    rw_q      <= rw_bit;
                    next_q    <= has_next;
                    limit_q   <= max_attempts;
                    timed_out <= 1'b0;
                    bus_held  <= 1'b0;
                    state     <= ST_START;
                end
                ST_START:  state <= ST_WSTART;
                ST_WSTART: if (cmd_done) state <= ST_ADDR;
                ST_ADDR:   state <= ST_WADDR;
                ST_WADDR: if (cmd_done) begin
                    if (cmd_ack) begin
                        if (next_q) begin
                            bus_held <= 1'b1;
                            state    <= ST_FIN;
                        end else begin
                            why   <= END_OK;
                            state <= ST_STOP;
                        end
                    end else if (exhausted) begin
                        why       <= END_TIMEOUT;
                        timed_out <= 1'b1;
                        state     <= ST_STOP;
                    end else begin
                        why   <= END_RETRY;
                        state <= ST_STOP;
                    end
                end
                ST_STOP:   state <= ST_WSTOP;
                ST_WSTOP: if (cmd_done) begin
                    state <= (why == END_RETRY) ? ST_START : ST_FIN;
                end
                ST_FIN:    state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Command requests toward the port and counter controls.
    always_comb begin
        issue     = (state == ST_START) || (state == ST_ADDR) || (state == ST_STOP);
        op        = (state == ST_START) ? OP_START :
                    (state == ST_ADDR)  ? OP_BYTE  : OP_STOP;
        wbyte     = {addr_q, rw_q};
        ctr_clear = (state == ST_IDLE) && req;
        ctr_bump  = (state == ST_ADDR);
        done      = (state == ST_FIN);
    end

    // The done pulse lasts one clock.
    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An open bus and a timeout never come together.
    assert_held_excludes_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(bus_held && timed_out));

    // Captured request fields stay put while busy.
    assert_capture_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(addr_q) && $stable(next_q) && $stable(rw_q)));

    // A closed-bus finish always comes straight from a completed STOP.
    assert_stop_before_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WSTOP && cmd_done && why != END_RETRY) |=> done && !bus_held);

endmodule

// File: rtl/ackpoll_master.sv
// Module: top of the write-completion acknowledge polling master.
// Joins the sequencer, the attempt counter and the engine command port.
// Assumes a byte engine that answers every command with one done pulse.
module ackpoll_master
    import ackpoll_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              rw_bit,
    input  logic              has_next,
    input  logic [CNT_W-1:0]  max_attempts,
    output logic              done,
    output logic              timed_out,
    output logic              bus_held,
    output logic [CNT_W-1:0]  attempts_used,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [ADDR_W:0]   eng_wdata,
    input  logic              eng_done,
    input  logic              eng_ack
);
    localparam int BYTE_W = ADDR_W + 1;

    logic              issue;
    bus_op_t           op;
    logic [BYTE_W-1:0] wbyte;
    logic              ctr_clear;
    logic              ctr_bump;
    logic [CNT_W-1:0]  limit_q;
    logic              exhausted;
    logic              cmd_done;
    logic              cmd_ack;

    ackpoll_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev_addr),
        .rw_bit(rw_bit), .has_next(has_next), .max_attempts(max_attempts),
        .cmd_done(cmd_done), .cmd_ack(cmd_ack), .exhausted(exhausted),
        .issue(issue), .op(op), .wbyte(wbyte), .ctr_clear(ctr_clear),
        .ctr_bump(ctr_bump), .limit_q(limit_q), .done(done),
        .timed_out(timed_out), .bus_held(bus_held)
    );

    ackpoll_attempt_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .bump(ctr_bump),
        .limit(limit_q), .count(attempts_used), .exhausted(exhausted)
    );

    ackpoll_cmd_port #(.BYTE_W(BYTE_W)) u_port (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .wbyte(wbyte),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .cmd_done(cmd_done),
        .cmd_ack(cmd_ack)
    );

endmodule

// File: tb/sim_ackpoll_master.sv
`timescale 1ns/1ps
// Bench: vector table of polling scenarios, then directed tests for
// reset, injected requests and mid-run reset. A byte-engine model
// answers each command after a fixed latency and refuses the first N
// address bytes of each run.
module sim_ackpoll_master;
    localparam int ENG_LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [6:0] dev_addr = '0;
    logic       rw_bit = 1'b0;
    logic       has_next = 1'b0;
    logic [7:0] max_attempts = '0;
    logic       done, timed_out, bus_held;
    logic [7:0] attempts_used;
    logic       eng_cmd_valid;
    logic [1:0] eng_cmd;
    logic [7:0] eng_wdata;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b0;

    int total = 0;
    int failed = 0;

    // Run configuration written by tests, read by the engine model.
    int         run_tag = 0;
    int         cfg_nack = 0;
    logic [7:0] cfg_byte = '0;

    // Observations kept by the engine model, cleared per run.
    int seen_tag = 0;
    int n_start = 0, n_byte = 0, n_stop = 0;
    int bad_byte = 0, bad_order = 0, overlap = 0, done_cycles = 0;
    int busy = 0, cnt = 0, prev = 3;
    logic resp = 1'b0;

    always #2 clk = ~clk;

    ackpoll_master u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .dev_addr(dev_addr),
        .rw_bit(rw_bit), .has_next(has_next), .max_attempts(max_attempts),
        .done(done), .timed_out(timed_out), .bus_held(bus_held),
        .attempts_used(attempts_used), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_done(eng_done),
        .eng_ack(eng_ack)
    );

    // Byte-engine and device model, sampled away from the active edge.
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (run_tag != seen_tag) begin
            seen_tag = run_tag;
            n_start = 0; n_byte = 0; n_stop = 0;
            bad_byte = 0; bad_order = 0; overlap = 0; done_cycles = 0;
            prev = 3;
        end
        if (!rst_n) begin
            busy = 0;
        end else begin
            if (done) done_cycles++;
            if (busy != 0) begin
                cnt--;
                if (cnt == 0) begin
                    eng_done = 1'b1;
                    eng_ack  = resp;
                    busy = 0;
                end
            end
            if (eng_cmd_valid) begin
                if (busy != 0) overlap++;
                case (eng_cmd)
                    2'd0: begin n_start++; resp = 1'b0; end
                    2'd1: begin
                        if (prev != 0) bad_order++;
                        if (eng_wdata != cfg_byte) bad_byte++;
                        resp = (n_byte >= cfg_nack);
                        n_byte++;
                    end
                    2'd2: begin
                        if (prev != 1) bad_order++;
                        n_stop++; resp = 1'b0;
                    end
                    default: bad_order++;
                endcase
                prev = int'(eng_cmd);
                busy = 1; cnt = ENG_LAT;
            end
        end
    end

    typedef struct packed {
        logic [7:0] nack;
        logic [7:0] maxa;
        logic       nxt;
        logic       rw;
        logic [6:0] addr;
        logic       exp_to;
        logic [7:0] exp_att;
        logic [7:0] exp_sp;
        logic       exp_held;
    } vec_t;

    // Expected results follow R5 to R8 (starts equal attempts).
    localparam vec_t VECS [8] = '{
        '{8'd0, 8'd4, 1'b0, 1'b0, 7'h50, 1'b0, 8'd1, 8'd1, 1'b0}, // R7 first-try ack
        '{8'd0, 8'd4, 1'b1, 1'b1, 7'h57, 1'b0, 8'd1, 8'd0, 1'b1}, // R6 held open
        '{8'd3, 8'd8, 1'b0, 1'b0, 7'h2A, 1'b0, 8'd4, 8'd4, 1'b0}, // R5 retries then close
        '{8'd3, 8'd8, 1'b1, 1'b1, 7'h11, 1'b0, 8'd4, 8'd3, 1'b1}, // R5/R6 retries then held
        '{8'd5, 8'd3, 1'b0, 1'b0, 7'h7F, 1'b1, 8'd3, 8'd3, 1'b0}, // R8 timeout
        '{8'd5, 8'd3, 1'b1, 1'b1, 7'h00, 1'b1, 8'd3, 8'd3, 1'b0}, // R8 timeout with next queued
        '{8'd2, 8'd3, 1'b0, 1'b1, 7'h3C, 1'b0, 8'd3, 8'd3, 1'b0}, // R8 ack on last attempt
        '{8'd1, 8'd0, 1'b1, 1'b0, 7'h05, 1'b1, 8'd1, 8'd1, 1'b0}  // R8 zero limit is one
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Launch one run, optionally inject a foreign request mid-run, check results.
    task automatic run_one(input vec_t v, input bit inject);
        int w;
        @(negedge clk);
        cfg_nack = int'(v.nack);
        cfg_byte = {v.addr, v.rw};
        run_tag++;
        dev_addr = v.addr; rw_bit = v.rw; has_next = v.nxt; max_attempts = v.maxa;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            dev_addr = ~v.addr; rw_bit = ~v.rw; has_next = ~v.nxt;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        w = 0;
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(w < 3000, "R9 watchdog on done", w, 3000);
        check(timed_out == v.exp_to, "R8 timed_out", int'(timed_out), int'(v.exp_to));
        check(bus_held == v.exp_held, "R6/R7 bus_held", int'(bus_held), int'(v.exp_held));
        check(attempts_used == v.exp_att, "R9 attempts_used", int'(attempts_used), int'(v.exp_att));
        repeat (2) @(negedge clk);
        check(done_cycles == 1, "R9 done width", done_cycles, 1);
        check(n_start == int'(v.exp_att), "R3 START count", n_start, int'(v.exp_att));
        check(n_byte == int'(v.exp_att), "R3 byte count", n_byte, int'(v.exp_att));
        check(n_stop == int'(v.exp_sp), "R5/R7 STOP count", n_stop, int'(v.exp_sp));
        check(bad_byte == 0, "R3/R2 address byte value", bad_byte, 0);
        check(bad_order == 0, "R3 command order", bad_order, 0);
        check(overlap == 0, "R4 single outstanding", overlap, 0);
    endtask

    // Global watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int snap;
        do_reset();
        // R1 reset state
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(eng_cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(eng_cmd_valid), 0);
        check(timed_out == 1'b0 && bus_held == 1'b0, "R1 flags after reset",
              int'({timed_out, bus_held}), 0);
        check(attempts_used == 8'd0, "R1 attempts after reset", int'(attempts_used), 0);
        repeat (5) @(negedge clk);
        check(n_start + n_byte + n_stop == 0, "R1 no command while idle",
              n_start + n_byte + n_stop, 0);

        foreach (VECS[i]) run_one(VECS[i], 1'b0);

        // R2 request and input changes mid-run are ignored
        run_one('{8'd3, 8'd8, 1'b0, 1'b1, 7'h46, 1'b0, 8'd4, 8'd4, 1'b0}, 1'b1);

        // R1 reset in the middle of a polling loop
        @(negedge clk);
        cfg_nack = 50; cfg_byte = {7'h22, 1'b0}; run_tag++;
        dev_addr = 7'h22; rw_bit = 1'b0; has_next = 1'b0; max_attempts = 8'd40;
        req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (15) @(negedge clk);
        do_reset();
        snap = n_start + n_byte + n_stop;
        check(eng_cmd_valid == 1'b0 && done == 1'b0, "R1 outputs after mid-run reset",
              int'({eng_cmd_valid, done}), 0);
        repeat (12) @(negedge clk);
        check(n_start + n_byte + n_stop == snap, "R1 idle after mid-run reset",
              n_start + n_byte + n_stop, snap);
        check(attempts_used == 8'd0 && timed_out == 1'b0, "R1 counter after mid-run reset",
              int'(attempts_used), 0);

        // Sequencer still works after the mid-run reset
        run_one(VECS[2], 1'b0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule